// File: doc/BRIEF.md
# Late-Write Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory whose reads are flow-through and whose writes are late. The host can issue read, write and read commands on consecutive edges over one shared data bus with no idle cycle between them. Every command input is sampled on the rising clock edge. A read drives its data in the cycle that follows its command edge. A write takes its data and lane enables on the edge after its command. Written data first sits in a one-entry staging register and reaches the array on the next write-data edge. A read of the staged address merges the staged lanes over the array word.

A two-bit burst generator steps the low address bits on continue cycles, in linear or interleaved order. An active-low clock enable freezes all command state. A sleep request, which is synchronised over two edges, floats the bus and suspends command processing while keeping the contents and state. The data bus is split into `din`, `dout` and a drive qualifier `dout_en`, which the chip-level pad logic combines into a bidirectional pin.

Top module: `zt_sram`

## Requirements
- R1: A load cycle (`adv`=0) selects the device only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect: nothing is written and `dout_en` is 0 in the following cycle.
- R2: For a read command at edge k, `dout` carries the addressed word, with `dout_en`=1, in the cycle after edge k, provided `out_en_n`=0. If `out_en_n`=1, `dout_en` is 0.
- R3: The data and lane enables of a write command at edge k are taken at the next enabled edge. `dout_en` stays 0 throughout write cycles, whatever the level of `out_en_n`.
- R4: `lane_wr_n[b]`=0 writes byte lane b (bits b*LW+LW-1 down to b*LW), and the other lanes keep their old value. A write cycle in which every lane bit is 1 stores nothing.
- R5: With `order_ilv`=0, the low two address bits on continue cycles follow start+1, start+2, start+3 (modulo 4). The upper bits keep their loaded value.
- R6: With `order_ilv`=1, the low two bits follow start XOR 1, start XOR 2, start XOR 3.
- R7: A continue cycle (`adv`=1) repeats the operation type of the burst and ignores the select and `wr_n` inputs. A continue that follows a deselect stays deselected.
- R8: The fourth continue after a load returns to the loaded address.
- R9: While `clk_en_n`=1, edges change no command state. A read in progress keeps driving `dout`, and a pending write waits for the next enabled edge to take its data.
- R10: When `sleep` is 1 at edge k, the block is asleep from edge k+1. While asleep, `dout_en`=0, commands and data are ignored, and the burst, operation and memory state are preserved.
- R11: A read of an address whose write data is held in the staging register returns the newest bytes of that write, merged by lane over the older array word.
- R12: After reset, `dout_en`=0 and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the command state |
| adv | input | 1 | 0 = load a new command, 1 = continue the burst |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| wr_n | input | 1 | 0 = write, 1 = read on a load cycle |
| lane_wr_n | input | LANES | Per-lane write enables, active low, sampled on the data edge |
| addr | input | AW | Word address |
| din | input | LANES*LW | Write data, one edge after its command |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request, active high |
| dout | output | LANES*LW | Read data; zero when not driven |
| dout_en | output | 1 | High while the block drives the data bus |

## Verification
The hard case is a write-data capture that falls in the same cycle as a read command to the same address. The staging register must be loaded while the read merges the bytes it already holds, and the earlier staged write must be committed to the array at that same edge. The bench provokes this by issuing a write and then, on the very next edge, a read of the same word, using partial lane masks and repeated writes to one address. It judges the result against a behavioural model that stores every write into its memory at once and has no staging at all. Any mistake in merging or committing therefore shows up as a data mismatch.

// File: rtl/zt_pkg.sv
package zt_pkg;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  // low address bits of beat idx within a four-beat burst
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] idx,
                                          input logic       ilv);
    return ilv ? (start ^ idx) : (start + idx);
  endfunction
endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
  import zt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic          ilv,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (step) begin
      if (load) begin
        base_q <= ext_addr;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign cur_addr = {base_q[AW-1:2], burst_lo(base_q[1:0], beat_q, ilv)};

  // R5: a load starts the burst at the external address
  p_load_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && load |=> cur_addr == $past(ext_addr));
  // R8: continue cycles stay inside the aligned group of four
  p_group_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]));
endmodule

// File: rtl/zt_wbuf.sv
module zt_wbuf #(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_go,
  input  logic [AW-1:0]       wr_addr,
  input  logic [LANES*LW-1:0] wr_data,
  input  logic [LANES-1:0]    wr_mask,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*LW-1:0] rd_data
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic             stg_v;
  logic [AW-1:0]    stg_a;
  logic [DW-1:0]    stg_d;
  logic [LANES-1:0] stg_m;
  logic             rd_hit;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0]    old_w,
                                               input logic [DW-1:0]    new_w,
                                               input logic [LANES-1:0] mask);
    logic [DW-1:0] r;
    r = old_w;
    for (int b = 0; b < LANES; b++)
      if (mask[b]) r[b*LW +: LW] = new_w[b*LW +: LW];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      stg_v <= 1'b0;
      stg_a <= '0;
      stg_d <= '0;
      stg_m <= '0;
    end else if (wr_go) begin
      if (stg_v) mem[stg_a] <= lane_merge(mem[stg_a], stg_d, stg_m);
      stg_v <= |wr_mask;
      stg_a <= wr_addr;
      stg_d <= wr_data;
      stg_m <= wr_mask;
    end
  end

  assign rd_hit  = stg_v && (stg_a == rd_addr);
  assign rd_data = lane_merge(mem[rd_addr], stg_d, rd_hit ? stg_m : '0);

  // R4: an all-lanes-off data phase leaves nothing staged
  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && !(|wr_mask) |=> !stg_v);
  // R11: staged bytes survive until the next data phase
  p_stage_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(stg_v) && $stable(stg_d) && $stable(stg_a));
endmodule

// File: rtl/zt_sleep_sync.sv
module zt_sleep_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      asleep <= 1'b0;
    end else begin
      s1_q   <= sleep_req;
      asleep <= s1_q;
    end
  end

  // R10: sleep is entered two edges after the request is seen
  p_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(sleep_req, 2));
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en_n,
  input  logic                adv,
  input  logic                sel_a_n,
  input  logic                sel_b,
  input  logic                sel_c_n,
  input  logic                wr_n,
  input  logic [LANES-1:0]    lane_wr_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] din,
  input  logic                out_en_n,
  input  logic                order_ilv,
  input  logic                sleep,
  output logic [LANES*LW-1:0] dout,
  output logic                dout_en
);
  localparam int DW = LANES * LW;

  logic          asleep;
  logic          step;
  logic          load;
  logic          sel;
  logic          wr_go;
  op_e           op_q;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] rd_data;

  assign step  = !clk_en_n && !asleep;
  assign load  = !adv;
  assign sel   = !sel_a_n && sel_b && !sel_c_n;
  assign wr_go = step && (op_q == OP_WR);

  zt_sleep_sync u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep),
    .asleep    (asleep)
  );

  zt_burst_gen #(.AW(AW)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (load),
    .ilv      (order_ilv),
    .ext_addr (addr),
    .cur_addr (cur_addr)
  );

  zt_wbuf #(.AW(AW), .LANES(LANES), .LW(LW)) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .wr_addr (cur_addr),
    .wr_data (din),
    .wr_mask (~lane_wr_n),
    .rd_addr (cur_addr),
    .rd_data (rd_data)
  );

  // operation of the current cycle; continue cycles keep it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      op_q <= OP_IDLE;
    else if (step && load)
      op_q <= !sel ? OP_IDLE : (wr_n ? OP_RD : OP_WR);
  end

  assign dout_en = (op_q == OP_RD) && !out_en_n && !asleep;
  assign dout    = dout_en ? rd_data : '0;

  // R1: a deselect load leaves the bus idle
  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step && load && !sel |=> !dout_en && op_q == OP_IDLE);
  // R3: no drive during a write cycle
  p_wr_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_q == OP_WR |-> !dout_en);
  // R7: continue cycles keep the operation type
  p_cont_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> op_q == $past(op_q));
  // R9: a disabled edge freezes the command state
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(op_q) && $stable(cur_addr));
  // R10: sleep preserves the command state
  p_sleep_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> $stable(op_q) && $stable(cur_addr));
endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int AW = 4, LANES = 4, LW = 8, DW = 32, DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, clk_en_n, adv, sel_a_n, sel_b, sel_c_n, wr_n;
  logic [LANES-1:0] lane_wr_n;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    din, dout;
  logic             out_en_n, order_ilv, sleep, dout_en;

  zt_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv(adv),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr), .din(din), .out_en_n(out_en_n),
    .order_ilv(order_ilv), .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  int    checks = 0, errors = 0;
  string req = "R12";
  bit    b_oe_n = 0, b_cke_n = 0, b_sleep = 0, b_ilv = 0;

  // behavioural reference: writes land in m_mem immediately
  logic [DW-1:0] m_mem [DEPTH];
  int m_op = 0, m_base = 0, m_idx = 0;
  bit m_s1 = 0, m_slp = 0;

  function automatic int m_addr();
    int lo, hi;
    lo = m_base % 4;
    hi = m_base - lo;
    return hi + (b_ilv ? (lo ^ m_idx) : ((lo + m_idx) % 4));
  endfunction

  task automatic check_out();
    bit exp_en;
    logic [DW-1:0] exp_d;
    exp_en = (m_op == 1) && !b_oe_n && !m_slp;
    exp_d  = m_mem[m_addr()];
    checks++;
    if (dout_en !== exp_en || (exp_en && dout !== exp_d)) begin
      errors++;
      $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
               req, dout_en, dout, exp_en, exp_d);
    end
  endtask

  task automatic model_edge();
    bit ns1, nslp;
    int a;
    ns1  = sleep;
    nslp = m_s1;
    if (!clk_en_n && !m_slp) begin
      if (m_op == 2) begin
        a = m_addr();
        for (int b = 0; b < LANES; b++)
          if (!lane_wr_n[b]) m_mem[a][b*LW +: LW] = din[b*LW +: LW];
      end
      if (!adv) begin
        m_base = int'(addr);
        m_idx  = 0;
        m_op   = (!sel_a_n && sel_b && !sel_c_n) ? (wr_n ? 1 : 2) : 0;
      end else begin
        m_idx = (m_idx + 1) % 4;
      end
    end
    m_s1  = ns1;
    m_slp = nslp;
  endtask

  // kind: 0 deselect(write attempt, first select off), 1 read, 2 write,
  // 3 continue with junk selects, 4 write with second select off,
  // 5 write with third select off
  task automatic cyc(int kind, int a, logic [DW-1:0] d, logic [LANES-1:0] ln_n);
    @(negedge clk);
    clk_en_n  = b_cke_n;
    out_en_n  = b_oe_n;
    order_ilv = b_ilv;
    sleep     = b_sleep;
    addr      = a[AW-1:0];
    din       = d;
    lane_wr_n = ln_n;
    adv = (kind == 3);
    sel_a_n = (kind == 0 || kind == 3);
    sel_b   = (kind != 4);
    sel_c_n = (kind == 5);
    wr_n    = (kind == 1);
    #3 check_out();
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL %s: watchdog expired, actual hung expected finished", req);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    rst_n = 0; clk_en_n = 0; adv = 0; sel_a_n = 1; sel_b = 1; sel_c_n = 0;
    wr_n = 1; lane_wr_n = '1; addr = '0; din = '0; out_en_n = 0;
    order_ilv = 0; sleep = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R12: idle bus after reset, memory reads zero
    req = "R12";
    #2 check_out();
    cyc(1, 3, 0, '1);
    cyc(1, 15, 0, '1);

    // R2/R3/R11: read-write-read with no gaps, reads hitting staged data
    req = "R2";
    cyc(2, 5, 0, '1);
    req = "R11";
    cyc(1, 5, 32'hA1B2C3D4, 4'b0000);
    cyc(2, 6, 0, '1);
    cyc(1, 6, 32'h11223344, 4'b0000);
    cyc(2, 5, 0, '1);
    cyc(1, 5, 32'hEEFF0011, 4'b1001);
    req = "R3";
    b_oe_n = 0;
    cyc(2, 7, 0, '1);
    cyc(2, 7, 32'h55555555, 4'b0000);
    cyc(1, 7, 32'h66666666, 4'b0101);
    cyc(1, 5, 0, '1);
    req = "R2";
    b_oe_n = 1;
    cyc(1, 6, 0, '1);
    cyc(0, 0, 0, '1);
    b_oe_n = 0;

    // R4: lane masking and write abort
    req = "R4";
    cyc(2, 8, 0, '1);
    cyc(2, 8, 32'hCAFEBABE, 4'b0000);
    cyc(2, 8, 32'h12345678, 4'b1010);
    cyc(1, 8, 32'h99999999, 4'b1111);
    cyc(1, 8, 0, '1);
    cyc(0, 0, 0, '1);

    // R5: linear write burst from 6, read back, then wrap (R8)
    req = "R5";
    b_ilv = 0;
    cyc(2, 6, 0, '1);
    cyc(3, 0, 32'h0A0A0A0A, 4'b0000);
    cyc(3, 0, 32'h0B0B0B0B, 4'b0000);
    cyc(3, 0, 32'h0C0C0C0C, 4'b0000);
    cyc(1, 6, 32'h0D0D0D0D, 4'b0000);
    cyc(3, 0, 0, '1);
    cyc(3, 0, 0, '1);
    cyc(3, 0, 0, '1);
    req = "R8";
    cyc(3, 0, 0, '1);
    cyc(3, 0, 0, '1);

    // R6: interleaved write burst from 9, read back
    req = "R6";
    b_ilv = 1;
    cyc(2, 9, 0, '1);
    cyc(3, 0, 32'h90909090, 4'b0000);
    cyc(3, 0, 32'h91919191, 4'b0000);
    cyc(3, 0, 32'h92929292, 4'b0000);
    cyc(1, 9, 32'h93939393, 4'b0000);
    cyc(3, 0, 0, '1);
    cyc(3, 0, 0, '1);
    cyc(3, 0, 0, '1);
    cyc(3, 0, 0, '1);
    cyc(1, 11, 0, '1);
    b_ilv = 0;
    cyc(0, 0, 0, '1);

    // R7: continue after deselect stays idle; junk selects ignored
    req = "R7";
    cyc(3, 0, 32'hDEADDEAD, 4'b0000);
    cyc(3, 0, 32'hDEADDEAD, 4'b0000);
    cyc(1, 4, 0, '1);
    cyc(3, 0, 0, '1);
    cyc(0, 0, 0, '1);

    // R9: stall during a read and during a write data phase
    req = "R9";
    cyc(1, 5, 0, '1);
    b_cke_n = 1;
    cyc(2, 2, 32'hBAD0BAD0, 4'b0000);
    cyc(2, 2, 32'hBAD1BAD1, 4'b0000);
    b_cke_n = 0;
    cyc(2, 10, 0, '1);
    b_cke_n = 1;
    cyc(1, 3, 32'hBAD2BAD2, 4'b0000);
    cyc(1, 3, 32'hBAD3BAD3, 4'b0000);
    b_cke_n = 0;
    cyc(1, 10, 32'h7E57DA7A, 4'b0000);
    cyc(1, 2, 0, '1);
    cyc(0, 0, 0, '1);

    // R10: sleep during a read; commands while asleep are ignored
    req = "R10";
    cyc(1, 10, 0, '1);
    b_sleep = 1;
    cyc(3, 0, 0, '1);
    cyc(0, 0, 0, '1);
    cyc(2, 11, 32'h1111EEEE, 4'b0000);
    cyc(1, 11, 32'h2222DDDD, 4'b0000);
    cyc(2, 12, 0, '1);
    b_sleep = 0;
    cyc(1, 12, 32'h3333CCCC, 4'b0000);
    cyc(3, 0, 0, '1);
    cyc(3, 0, 0, '1);
    cyc(1, 11, 0, '1);
    cyc(0, 0, 0, '1);

    // R1: each wrong select combination blocks a write
    req = "R1";
    cyc(0, 13, 0, '1);
    cyc(4, 13, 32'hF0F0F0F0, 4'b0000);
    cyc(5, 13, 32'hF1F1F1F1, 4'b0000);
    cyc(1, 13, 32'hF2F2F2F2, 4'b0000);
    cyc(0, 0, 0, '1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule